// File: doc/BRIEF.md
# Striped Register Bank Port Arbiter

This block sits between a set of function units and a register file that is split into banks by register number. A register's bank is given by the low bits of its number, so with two banks every second register shares a bank and with four banks every fourth one does. Each function unit also has a home bank, which is its own index modulo the bank count. A unit reads its home bank through a private port that is always available. A read from any other bank has to pass through that bank's single shared crossing multiplexer. A round-robin arbiter in each bank decides which of the competing units gets the crossing multiplexer in a given cycle.

Writes never cross banks. A unit writes only to registers in its home bank, so no destination multiplexer is needed. A write aimed at any other bank is dropped and reported on an error output. The register storage is held inside the block as plain arrays. Dependency tracking is left to the surrounding logic. A unit that loses arbitration simply holds its read request until it is granted.

Top module: `striped_bank_arbiter`

## Requirements
- R1: The bank of a register is its number's low log2(NUM_BANKS) bits. The row inside the bank is the remaining upper bits. The home bank of unit u is u mod NUM_BANKS, and NUM_BANKS is a parameter that must be 2 or 4.
- R2: After reset every register reads as zero, every arbiter pointer is 0 and wr_err is all zero.
- R3: A read request whose register lies in the requester's home bank is granted in the same cycle. rd_data then carries the register's current contents in the same cycle.
- R4: Each bank grants at most one crossing read per cycle. The granted unit receives that bank's register contents on rd_data in the same cycle.
- R5: In each bank the crossing grant goes to the first requesting foreign unit found by scanning unit indices upward, wrapping around, starting at the bank's pointer. After a grant the pointer becomes the winner's index plus one, modulo NUM_FU. With no grant the pointer is unchanged.
- R6: rd_grant[u] is never high without rd_req[u]. When rd_grant[u] is low, rd_data for unit u is zero.
- R7: A write to a register in the writer's home bank updates it at the clock edge. A read of that register in the same cycle returns the old value, and reads from the next cycle return the new one.
- R8: A write to a register outside the writer's home bank leaves every register unchanged. It sets wr_err[u] high for exactly the following cycle.
- R9: When two units with the same home bank write the same register in one cycle, the value from the higher-numbered unit is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | NUM_FU | Read request, one bit per unit |
| rd_addr | input | NUM_FU*log2(NUM_REGS) | Register number per unit, unit u in slice u |
| rd_grant | output | NUM_FU | Read granted this cycle |
| rd_data | output | NUM_FU*DATA_W | Read data per unit, zero when not granted |
| wr_req | input | NUM_FU | Write request, one bit per unit |
| wr_addr | input | NUM_FU*log2(NUM_REGS) | Write register number per unit |
| wr_data | input | NUM_FU*DATA_W | Write data per unit |
| wr_err | output | NUM_FU | Previous cycle's write targeted a foreign bank |

## Verification
The assertions assume that reset is applied before the first request. They also assume rd_req and wr_req are known on every clock edge, and that the parameters satisfy the elaboration checks: two or four banks, and unit and register counts that divide evenly into banks. The stimulus never drives X, releases reset between edges, and changes inputs only just after a rising edge. Every grant and error is therefore produced from a stable, fully defined request set. Contention cases hold requests steady over several cycles, as a stalled unit would, so the pointer rotation can be followed.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

   // home bank of a function unit: its index modulo the bank count
   function automatic int home_bank(input int unit_idx, input int nbanks);
      return unit_idx % nbanks;
   endfunction

   // slot of a unit among the units sharing its home bank
   function automatic int home_slot(input int unit_idx, input int nbanks);
      return unit_idx / nbanks;
   endfunction

   // unit index owning slot k of bank b
   function automatic int slot_unit(input int bank_idx, input int slot, input int nbanks);
      return slot * nbanks + bank_idx;
   endfunction

endpackage

// File: rtl/sbank_rr_arbiter.sv
module sbank_rr_arbiter #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] win;
   logic          found;

   // scan upward from the pointer, wrapping at N
   always_comb begin
      int idx;
      gnt   = '0;
      win   = ptr_q;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         idx = int'(ptr_q) + i;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
            win      = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (found) begin
         ptr_q <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
      end
   end

   p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("more than one crossing grant");

   p_grant_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("grant without request");

   p_work_conserving_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt)) else $error("requests pending but nothing granted");

endmodule

// File: rtl/sbank_bank_store.sv
module sbank_bank_store #(
   parameter int ROWS   = 8,
   parameter int DATA_W = 32,
   parameter int NUM_RD = 3,
   parameter int NUM_WR = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_RD*$clog2(ROWS)-1:0]    rd_row,
   output logic [NUM_RD*DATA_W-1:0]          rd_dat,
   input  logic [NUM_WR-1:0]                 wr_en,
   input  logic [NUM_WR*$clog2(ROWS)-1:0]    wr_row,
   input  logic [NUM_WR*DATA_W-1:0]          wr_dat
);
   localparam int RA = $clog2(ROWS);

   logic [DATA_W-1:0] mem_q [ROWS];

   // later write ports override earlier ones on a shared row
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
      end else begin
         for (int k = 0; k < NUM_WR; k++) begin
            if (wr_en[k]) mem_q[wr_row[k*RA +: RA]] <= wr_dat[k*DATA_W +: DATA_W];
         end
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_dat[p*DATA_W +: DATA_W] = mem_q[rd_row[p*RA +: RA]];
   end

endmodule

// File: rtl/striped_bank_arbiter.sv
module striped_bank_arbiter
   import sbank_pkg::*;
#(
   parameter int NUM_FU    = 8,
   parameter int NUM_BANKS = 4,
   parameter int NUM_REGS  = 32,
   parameter int DATA_W    = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_FU-1:0]                    rd_req,
   input  logic [NUM_FU*$clog2(NUM_REGS)-1:0]   rd_addr,
   output logic [NUM_FU-1:0]                    rd_grant,
   output logic [NUM_FU*DATA_W-1:0]             rd_data,
   input  logic [NUM_FU-1:0]                    wr_req,
   input  logic [NUM_FU*$clog2(NUM_REGS)-1:0]   wr_addr,
   input  logic [NUM_FU*DATA_W-1:0]             wr_data,
   output logic [NUM_FU-1:0]                    wr_err
);
   localparam int REG_AW   = $clog2(NUM_REGS);
   localparam int BANK_W   = $clog2(NUM_BANKS);
   localparam int ROW_AW   = REG_AW - BANK_W;
   localparam int ROWS     = NUM_REGS / NUM_BANKS;
   localparam int PER_BANK = NUM_FU / NUM_BANKS;

   // elaboration-time parameter checks
   if (NUM_BANKS != 2 && NUM_BANKS != 4) begin : g_bad_banks
      $error("NUM_BANKS must be 2 or 4");
   end
   if (NUM_FU % NUM_BANKS != 0) begin : g_bad_fu
      $error("NUM_FU must be a multiple of NUM_BANKS");
   end
   if ((1 << REG_AW) != NUM_REGS || NUM_REGS < 2 * NUM_BANKS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least twice NUM_BANKS");
   end

   // per-unit decode
   logic [REG_AW-1:0] rd_reg  [NUM_FU];
   logic [REG_AW-1:0] wr_reg  [NUM_FU];
   logic [DATA_W-1:0] wr_val  [NUM_FU];
   logic [BANK_W-1:0] rd_bank [NUM_FU];
   logic [BANK_W-1:0] wr_bank [NUM_FU];
   logic [NUM_FU-1:0] rd_home;
   logic [NUM_FU-1:0] wr_home;

   always_comb begin
      for (int u = 0; u < NUM_FU; u++) begin
         rd_reg[u]  = rd_addr[u*REG_AW +: REG_AW];
         wr_reg[u]  = wr_addr[u*REG_AW +: REG_AW];
         wr_val[u]  = wr_data[u*DATA_W +: DATA_W];
         rd_bank[u] = rd_reg[u][BANK_W-1:0];
         wr_bank[u] = wr_reg[u][BANK_W-1:0];
         rd_home[u] = (rd_bank[u] == BANK_W'(home_bank(u, NUM_BANKS)));
         wr_home[u] = (wr_bank[u] == BANK_W'(home_bank(u, NUM_BANKS)));
      end
   end

   // crossing requests per bank
   logic [NUM_FU-1:0] x_req [NUM_BANKS];
   logic [NUM_FU-1:0] x_gnt [NUM_BANKS];
   logic [ROW_AW-1:0] x_row [NUM_BANKS];
   logic [DATA_W-1:0] x_dat [NUM_BANKS];

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int u = 0; u < NUM_FU; u++) begin
            x_req[b][u] = rd_req[u] && !rd_home[u] && (rd_bank[u] == BANK_W'(b));
         end
      end
   end

   // crossing mux select: row of the granted foreign unit
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         x_row[b] = '0;
         for (int u = 0; u < NUM_FU; u++) begin
            if (x_gnt[b][u]) x_row[b] = x_row[b] | rd_reg[u][REG_AW-1:BANK_W];
         end
      end
   end

   // home-port wiring: fixed, no multiplexing
   logic [PER_BANK*ROW_AW-1:0] h_row  [NUM_BANKS];
   logic [PER_BANK*DATA_W-1:0] h_dat  [NUM_BANKS];
   logic [PER_BANK-1:0]        b_wen  [NUM_BANKS];
   logic [PER_BANK*ROW_AW-1:0] b_wrow [NUM_BANKS];
   logic [PER_BANK*DATA_W-1:0] b_wdat [NUM_BANKS];

   always_comb begin
      int u;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int k = 0; k < PER_BANK; k++) begin
            u = slot_unit(b, k, NUM_BANKS);
            h_row[b][k*ROW_AW +: ROW_AW]  = rd_reg[u][REG_AW-1:BANK_W];
            b_wen[b][k]                   = wr_req[u] && wr_home[u];
            b_wrow[b][k*ROW_AW +: ROW_AW] = wr_reg[u][REG_AW-1:BANK_W];
            b_wdat[b][k*DATA_W +: DATA_W] = wr_val[u];
         end
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [(PER_BANK+1)*DATA_W-1:0] bank_rd;

      sbank_rr_arbiter #(
         .N (NUM_FU)
      ) arb_i (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (x_req[b]),
         .gnt   (x_gnt[b])
      );

      sbank_bank_store #(
         .ROWS   (ROWS),
         .DATA_W (DATA_W),
         .NUM_RD (PER_BANK + 1),
         .NUM_WR (PER_BANK)
      ) store_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_row ({x_row[b], h_row[b]}),
         .rd_dat (bank_rd),
         .wr_en  (b_wen[b]),
         .wr_row (b_wrow[b]),
         .wr_dat (b_wdat[b])
      );

      assign h_dat[b] = bank_rd[PER_BANK*DATA_W-1:0];
      assign x_dat[b] = bank_rd[PER_BANK*DATA_W +: DATA_W];
   end

   // return path to each unit
   always_comb begin
      int hb;
      int hs;
      for (int u = 0; u < NUM_FU; u++) begin
         hb = home_bank(u, NUM_BANKS);
         hs = home_slot(u, NUM_BANKS);
         rd_grant[u]                 = 1'b0;
         rd_data[u*DATA_W +: DATA_W] = '0;
         if (rd_req[u]) begin
            if (rd_home[u]) begin
               rd_grant[u]                 = 1'b1;
               rd_data[u*DATA_W +: DATA_W] = h_dat[hb][hs*DATA_W +: DATA_W];
            end else if (x_gnt[rd_bank[u]][u]) begin
               rd_grant[u]                 = 1'b1;
               rd_data[u*DATA_W +: DATA_W] = x_dat[rd_bank[u]];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_err <= '0;
      end else begin
         for (int u = 0; u < NUM_FU; u++) wr_err[u] <= wr_req[u] && !wr_home[u];
      end
   end

   for (genvar u = 0; u < NUM_FU; u++) begin : g_unit_chk
      p_home_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req[u] && rd_addr[u*REG_AW +: BANK_W] == BANK_W'(u % NUM_BANKS)) |-> rd_grant[u])
         else $error("home read not granted");

      p_grant_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_grant[u] |-> rd_req[u]) else $error("read grant without request");

      p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
         wr_err[u] |-> $past(wr_req[u])) else $error("write error without a write");
   end

endmodule

// File: tb/striped_bank_arbiter_tb.sv
module striped_bank_arbiter_tb_top;
   localparam int NFU = 8;
   localparam int NB  = 4;
   localparam int NR  = 16;
   localparam int DW  = 8;
   localparam int AW  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NFU-1:0]    rd_req, wr_req, rd_grant, wr_err;
   logic [NFU*AW-1:0] rd_addr, wr_addr;
   logic [NFU*DW-1:0] wr_data, rd_data;
   logic [AW-1:0]     ra [NFU];
   logic [AW-1:0]     wa [NFU];
   logic [DW-1:0]     wd [NFU];

   always_comb begin
      for (int u = 0; u < NFU; u++) begin
         rd_addr[u*AW +: AW] = ra[u];
         wr_addr[u*AW +: AW] = wa[u];
         wr_data[u*DW +: DW] = wd[u];
      end
   end

   striped_bank_arbiter #(
      .NUM_FU (NFU), .NUM_BANKS (NB), .NUM_REGS (NR), .DATA_W (DW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .rd_req (rd_req), .rd_addr (rd_addr), .rd_grant (rd_grant), .rd_data (rd_data),
      .wr_req (wr_req), .wr_addr (wr_addr), .wr_data (wr_data), .wr_err (wr_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [DW-1:0]  mm [NR];
   int             ptr [NB];
   logic [NFU-1:0] exp_err;
   logic [31:0]    seed;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic clear();
      rd_req = '0;
      wr_req = '0;
      for (int u = 0; u < NFU; u++) begin
         ra[u] = '0; wa[u] = '0; wd[u] = '0;
      end
   endtask

   // inputs are set just after a rising edge; check at the falling edge, then model the next edge
   task automatic step(input string tag);
      int win [NB];
      int bk;
      int eg;
      int ed;
      string gt;
      logic [NFU-1:0] nerr;
      @(negedge clk);
      #2;
      for (int b = 0; b < NB; b++) begin
         win[b] = -1;
         for (int i = 0; i < NFU; i++) begin
            int idx;
            idx = (ptr[b] + i) % NFU;
            if (win[b] < 0 && rd_req[idx] && (int'(ra[idx]) % NB) == b && (idx % NB) != b)
               win[b] = idx;
         end
      end
      for (int u = 0; u < NFU; u++) begin
         bk = int'(ra[u]) % NB;
         eg = 0;
         if (rd_req[u]) eg = ((bk == u % NB) || (win[bk] == u)) ? 1 : 0;
         gt = !rd_req[u] ? "R6" : ((bk == u % NB) ? "R3" : "R5");
         chk(gt, $sformatf("grant u%0d", u), int'(rd_grant[u]), eg);
         ed = (eg != 0) ? int'(mm[ra[u]]) : 0;
         chk((eg != 0) ? tag : "R6", $sformatf("data u%0d", u), int'(rd_data[u*DW +: DW]), ed);
         chk("R8", $sformatf("wr_err u%0d", u), int'(wr_err[u]), int'(exp_err[u]));
      end
      for (int b = 0; b < NB; b++) if (win[b] >= 0) ptr[b] = (win[b] + 1) % NFU;
      for (int u = 0; u < NFU; u++) begin
         nerr[u] = wr_req[u] && ((int'(wa[u]) % NB) != (u % NB));
         if (wr_req[u] && !nerr[u]) mm[wa[u]] = wd[u];
      end
      exp_err = nerr;
      @(posedge clk);
      #1;
   endtask

   task automatic read_all(input string tag);
      for (int r = 0; r < NR; r++) begin
         clear();
         rd_req[(r % NB) + NB] = 1'b1;
         ra[(r % NB) + NB]     = AW'(r);
         step(tag);
      end
   endtask

   initial begin
      clear();
      exp_err = '0;
      seed    = 32'h1234_5678;
      for (int r = 0; r < NR; r++) mm[r] = '0;
      for (int b = 0; b < NB; b++) ptr[b] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R2: reset contents and quiet error flags
      step("R2");
      for (int r = 0; r < NR; r++) begin
         clear();
         rd_req[r % NB] = 1'b1;
         ra[r % NB]     = AW'(r);
         step("R2");
      end

      // R7: home writes with same-cycle read returning the old value
      for (int r = 0; r < NR; r++) begin
         int u;
         u = (r % NB) + NB * ((r / NB) % 2);
         clear();
         wr_req[u] = 1'b1; wa[u] = AW'(r); wd[u] = DW'(r * 29 + 5);
         rd_req[u] = 1'b1; ra[u] = AW'(r);
         step("R7");
      end
      read_all("R7");

      // R8: every foreign write from every unit is dropped and flagged
      for (int u = 0; u < NFU; u++) begin
         for (int r = 0; r < NR; r++) begin
            if (r % NB != u % NB) begin
               clear();
               wr_req[u] = 1'b1; wa[u] = AW'(r); wd[u] = 8'hA5;
               step("R8");
            end
         end
      end
      clear();
      step("R8");
      read_all("R8");

      // R9: same register written by two units of one bank
      clear();
      wr_req[1] = 1'b1; wa[1] = 4'd5; wd[1] = 8'h11;
      wr_req[5] = 1'b1; wa[5] = 4'd5; wd[5] = 8'h55;
      step("R9");
      clear();
      wr_req[0] = 1'b1; wa[0] = 4'd8;  wd[0] = 8'h08;
      wr_req[4] = 1'b1; wa[4] = 4'd12; wd[4] = 8'h0C;
      rd_req[1] = 1'b1; ra[1] = 4'd5;
      step("R9");
      read_all("R9");

      // R5: held contention on bank 0, rotation through all foreign units
      clear();
      for (int u = 0; u < NFU; u++) begin
         rd_req[u] = 1'b1;
         ra[u]     = AW'((u % NB) * NB);
      end
      repeat (10) step("R5");

      // R1: request pattern sweep over all address mappings
      for (int p = 0; p < 256; p++) begin
         clear();
         rd_req = NFU'(p);
         for (int u = 0; u < NFU; u++) ra[u] = AW'((u * 5 + p + (p >> 3)) % NR);
         step("R1");
      end

      // R4: mixed reads and writes from a linear congruential sequence
      for (int n = 0; n < 1200; n++) begin
         clear();
         seed   = seed * 32'd1103515245 + 32'd12345;
         rd_req = seed[23:16];
         wr_req = seed[15:8] & seed[31:24];
         for (int u = 0; u < NFU; u++) begin
            seed  = seed * 32'd1103515245 + 32'd12345;
            ra[u] = seed[19:16];
            wa[u] = seed[23:20];
            wd[u] = seed[31:24];
         end
         step("R4");
      end
      clear();
      step("R4");

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R4 watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule